// File: doc/BRIEF.md
# Hierarchical Reset Controller

This block owns the reset tree of a multi-function communications device. It merges an active-low board reset pin with a software-controlled global reset bit to form one internal global reset. Below that sits a software reset for the serial-interface domain. A separate control bit fires a one-cycle reset pulse to the queue pointers. A processor reaches all the reset bits through a small synchronous register port: one write strobe, an address, write data, and combinational read data.

The reset bits are sticky and do not clear themselves through the reset they cause. Global reset clears the serial-interface bit, and the serial-interface reset never touches the global bit. Software can hold either the pin or the global bit active for as long as it likes, which parks the device in a low-power state. The block deasserts a bus output enable while the pin is low, so the processor bus outputs go high-impedance. A reset-done flag lets software wait out the settling time after every reset has been released.

Top module: `rst_ctrl_top`

## Requirements
- R1: `globalRstN` is low whenever the synchronized pin reset is active or the global bit (address 0, bit 0) is one.
- R2: The global bit becomes one on a write of 1 to address 0 bit 0. It returns to zero only on a write of 0 there or while the pin is low. Its own global reset does not clear it.
- R3: A low pin asserts the internal reset at once, without waiting for a clock. Release takes effect after the second rising clock edge that follows the pin going high.
- R4: `busOe` is low while the pin is low and until the internal reset is released, and high otherwise.
- R5: The serial bit (address 1, bit 0) is sticky once written to 1. It is cleared by a write of 0, by a low pin, or within one cycle of the global bit being one.
- R6: `serRstN` is low whenever the serial bit is one or global reset is active. Serial reset changes neither the serial bit nor the global bit.
- R7: While the global bit is one, writes to address 1 and address 2 are ignored.
- R8: Writing 1 to address 2 bit 0 drives `qptrRstN` low for exactly the one cycle after the write edge. Address 2 always reads as zero. `qptrRstN` is also low during global reset.
- R9: The done flag (address 3, bit 0, read-only) is zero while any reset is active. It becomes one DONE_CYC rising edges after the edge that released the last reset.
- R10: Only bit 0 of write data is used. All other read bits are zero.
- R11: A global bit held at one keeps `globalRstN` and `serRstN` low indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| extRstN | input | 1 | Board reset pin, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr`, combinational |
| busOe | output | 1 | Processor bus output enable |
| globalRstN | output | 1 | Global domain reset, active low |
| serRstN | output | 1 | Serial-interface domain reset, active low |
| qptrRstN | output | 1 | Queue-pointer reset pulse, active low |

## Verification
The bound checker watches the nesting on every cycle:
- A global reset always forces the serial reset.
- A set global bit clears the serial bit on the next cycle.
- The global bit holds unless address 0 is written.
- A queue-pointer pulse only ever follows a matching write.
- The done flag drops after any reset.
- A low pin always disables the bus outputs.

Other behaviours need the bench's scenarios:
- The exact two-edge release after the pin goes high.
- The DONE_CYC count to the done flag.
- Writes that are ignored while the global bit is set.
- Readback of each register after sequences of writes.
- A global reset held for many cycles.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  // register map; bit 0 of each word is the only live field
  localparam int unsigned ADDR_GBL  = 0;
  localparam int unsigned ADDR_SER  = 1;
  localparam int unsigned ADDR_QPTR = 2;
  localparam int unsigned ADDR_STAT = 3;

  // strobes from control decode to the reset datapath
  typedef struct packed {
    logic gblWr;
    logic gblVal;
    logic serWr;
    logic serVal;
    logic qptrPulse;
  } rst_stb_t;
endpackage

// File: rtl/rst_ctrl_sync.sv
module rst_ctrl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic asyncRstN,
  output logic syncRstN
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge asyncRstN) begin
          if (!asyncRstN) chain[i] <= 1'b0;
          else            chain[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge asyncRstN) begin
          if (!asyncRstN) chain[i] <= 1'b0;
          else            chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncRstN = chain[STAGES-1];
endmodule

// File: rtl/rst_ctrl_ctl.sv
module rst_ctrl_ctl
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              gblBit,
  output logic              pinRstN,
  output rst_stb_t          stb
);
  logic writeHit;
  logic dataBit;
  logic unusedHiBits;

  rst_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .asyncRstN(extRstN),
    .syncRstN (pinRstN)
  );

  assign writeHit     = wrEn && pinRstN;
  assign dataBit      = wrData[0];
  assign unusedHiBits = ^wrData[DATA_W-1:1];

  always_comb begin
    stb           = '0;
    stb.gblVal    = dataBit;
    stb.serVal    = dataBit;
    stb.gblWr     = writeHit && (addr == ADDR_W'(ADDR_GBL));
    stb.serWr     = writeHit && !gblBit && (addr == ADDR_W'(ADDR_SER));
    stb.qptrPulse = writeHit && !gblBit && dataBit && (addr == ADDR_W'(ADDR_QPTR));
  end
endmodule

// File: rtl/rst_ctrl_dp.sv
module rst_ctrl_dp
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DONE_CYC = 16
) (
  input  logic              clk,
  input  logic              pinRstN,
  input  rst_stb_t          stb,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData,
  output logic              gblBit,
  output logic              serBit,
  output logic              globalRstN,
  output logic              serRstN,
  output logic              qptrRstN
);
  localparam int unsigned CNT_W = $clog2(DONE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DONE_CYC);

  logic             gblRst;
  logic             serRst;
  logic             qPulse;
  logic [CNT_W-1:0] settleCnt;
  logic             rstDone;

  always_ff @(posedge clk or negedge pinRstN) begin
    if (!pinRstN)       gblRst <= 1'b0;
    else if (stb.gblWr) gblRst <= stb.gblVal;
  end

  always_ff @(posedge clk or negedge pinRstN) begin
    if (!pinRstN)       serRst <= 1'b0;
    else if (gblRst)    serRst <= 1'b0;
    else if (stb.serWr) serRst <= stb.serVal;
  end

  always_ff @(posedge clk or negedge pinRstN) begin
    if (!pinRstN) qPulse <= 1'b0;
    else          qPulse <= stb.qptrPulse;
  end

  always_ff @(posedge clk or negedge pinRstN) begin
    if (!pinRstN)                 settleCnt <= '0;
    else if (gblRst || serRst)    settleCnt <= '0;
    else if (settleCnt != CNT_END) settleCnt <= settleCnt + 1'b1;
  end

  assign rstDone    = (settleCnt == CNT_END) && !gblRst && !serRst;
  assign globalRstN = pinRstN && !gblRst;
  assign serRstN    = globalRstN && !serRst;
  assign qptrRstN   = globalRstN && !qPulse;
  assign gblBit     = gblRst;
  assign serBit     = serRst;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(ADDR_GBL):  rdData[0] = gblRst;
      ADDR_W'(ADDR_SER):  rdData[0] = serRst;
      ADDR_W'(ADDR_STAT): rdData[0] = rstDone;
      default:            rdData = '0;
    endcase
  end
endmodule

// File: rtl/rst_ctrl_top.sv
module rst_ctrl_top
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DONE_CYC    = 16
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busOe,
  output logic              globalRstN,
  output logic              serRstN,
  output logic              qptrRstN
);
  rst_stb_t stb;
  logic     pinRstN;
  logic     gblBit;
  logic     serBit;

  rst_ctrl_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctl (
    .clk    (clk),
    .extRstN(extRstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .gblBit (gblBit),
    .pinRstN(pinRstN),
    .stb    (stb)
  );

  rst_ctrl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DONE_CYC(DONE_CYC)
  ) u_dp (
    .clk       (clk),
    .pinRstN   (pinRstN),
    .stb       (stb),
    .addr      (addr),
    .rdData    (rdData),
    .gblBit    (gblBit),
    .serBit    (serBit),
    .globalRstN(globalRstN),
    .serRstN   (serRstN),
    .qptrRstN  (qptrRstN)
  );

  assign busOe = pinRstN;
endmodule

// File: rtl/rst_ctrl_chk.sv
module rst_ctrl_chk
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              extRstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              busOe,
  input logic              globalRstN,
  input logic              serRstN,
  input logic              qptrRstN,
  input logic              gblBit,
  input logic              serBit
);
  logic wrGblAddr;
  logic wrQptrOne;
  logic doneFlag;

  assign wrGblAddr = wrEn && (addr == ADDR_W'(ADDR_GBL));
  assign wrQptrOne = wrEn && wrData[0] && (addr == ADDR_W'(ADDR_QPTR));
  assign doneFlag  = (addr == ADDR_W'(ADDR_STAT)) && rdData[0];

  assert_gbl_forces_global_R1: assert property (@(posedge clk) disable iff (!extRstN)
    gblBit |-> !globalRstN);

  assert_gbl_sticky_R2: assert property (@(posedge clk) disable iff (!extRstN)
    (gblBit && !wrGblAddr) |=> gblBit);

  always @(posedge clk) begin
    if (!extRstN) begin
      assert_bus_hiz_R4: assert (!busOe);
    end
  end

  assert_gbl_clears_ser_R5: assert property (@(posedge clk) disable iff (!extRstN)
    (gblBit && serBit) |=> !serBit);

  assert_ser_nested_R6: assert property (@(posedge clk) disable iff (!extRstN)
    !globalRstN |-> !serRstN);

  assert_ser_write_blocked_R7: assert property (@(posedge clk) disable iff (!extRstN)
    (gblBit && !serBit) |=> !serBit);

  assert_qptr_from_write_R8: assert property (@(posedge clk) disable iff (!extRstN)
    (!qptrRstN && globalRstN) |-> $past(wrQptrOne));

  assert_done_drops_R9: assert property (@(posedge clk) disable iff (!extRstN)
    (gblBit || serBit) |=> !doneFlag);
endmodule

bind rst_ctrl_top rst_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .extRstN   (extRstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .rdData    (rdData),
  .busOe     (busOe),
  .globalRstN(globalRstN),
  .serRstN   (serRstN),
  .qptrRstN  (qptrRstN),
  .gblBit    (gblBit),
  .serBit    (serBit)
);

// File: tb/rst_ctrl_top_tb.sv
module rst_ctrl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 2;
  localparam int DATA_W     = 8;
  localparam int DONE_CYC   = 8;

  logic              clk = 1'b0;
  logic              extRstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              busOe, globalRstN, serRstN, qptrRstN;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_ctrl_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2), .DONE_CYC(DONE_CYC)) u_dut (
    .clk(clk), .extRstN(extRstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .busOe(busOe), .globalRstN(globalRstN),
    .serRstN(serRstN), .qptrRstN(qptrRstN)
  );

  // vector: {write addr, write data, exp globalRstN, exp serRstN, exp gbl bit, exp ser bit}
  localparam logic [13:0] VEC [11] = '{
    {2'd1, 8'h01, 4'b1001},
    {2'd1, 8'h00, 4'b1100},
    {2'd1, 8'h01, 4'b1001},
    {2'd0, 8'h01, 4'b0010},
    {2'd1, 8'h01, 4'b0010},
    {2'd0, 8'h00, 4'b1100},
    {2'd1, 8'h01, 4'b1001},
    {2'd0, 8'h00, 4'b1001},
    {2'd1, 8'hFE, 4'b1100},
    {2'd0, 8'hFF, 4'b0010},
    {2'd0, 8'h00, 4'b1100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int settle);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    repeat (settle) @(negedge clk);
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] rd;

    // R3 R4 pin reset and release timing
    repeat (3) @(negedge clk);
    #1;
    check("R4 bus off while pin low", busOe, 0);
    check("R1 global active while pin low", globalRstN, 0);
    @(negedge clk);
    extRstN = 1'b1;
    @(negedge clk);
    check("R3 still held after one edge", globalRstN, 0);
    check("R4 still off after one edge", busOe, 0);
    @(negedge clk);
    check("R3 released after two edges", globalRstN, 1);
    check("R4 bus on after release", busOe, 1);
    check("R6 serial reset released", serRstN, 1);
    check("R8 qptr idle", qptrRstN, 1);
    readReg(2'd0, rd); check("R2 global bit reset value", rd, 0);
    readReg(2'd1, rd); check("R5 serial bit reset value", rd, 0);
    repeat (20) @(negedge clk);
    readReg(2'd3, rd); check("R9 done after settling", rd, 1);

    // table walk: R1 R2 R5 R6 R7 R10
    foreach (VEC[i]) begin
      writeReg(VEC[i][13:12], VEC[i][11:4], 1);
      check("R1 R6 globalRstN vector", globalRstN, VEC[i][3]);
      check("R6 R7 serRstN vector", serRstN, VEC[i][2]);
      readReg(2'd0, rd); check("R2 R10 global readback", rd, {7'b0, VEC[i][1]});
      readReg(2'd1, rd); check("R5 R7 R10 serial readback", rd, {7'b0, VEC[i][0]});
    end

    // R8 queue pointer pulse
    writeReg(2'd2, 8'h01, 0);
    check("R8 pulse low one cycle", qptrRstN, 0);
    readReg(2'd2, rd); check("R8 qptr reads zero", rd, 0);
    @(negedge clk);
    check("R8 pulse ends", qptrRstN, 1);
    writeReg(2'd2, 8'h02, 0);
    check("R10 qptr bit1 ignored", qptrRstN, 1);

    // R7 qptr write ignored under global reset, observed after release
    writeReg(2'd0, 8'h01, 1);
    check("R8 qptr low in global reset", qptrRstN, 0);
    writeReg(2'd2, 8'h01, 0);
    writeReg(2'd0, 8'h00, 0);
    check("R7 no pulse after blocked write", qptrRstN, 1);

    // R9 exact settle count
    repeat (20) @(negedge clk);
    writeReg(2'd0, 8'h01, 1);
    readReg(2'd3, rd); check("R9 done low in global reset", rd, 0);
    writeReg(2'd0, 8'h00, 0);
    readReg(2'd3, rd);
    repeat (DONE_CYC - 1) @(negedge clk);
    #1; check("R9 done low one edge early", rdData, 0);
    @(negedge clk);
    #1; check("R9 done high at count", rdData, 1);

    // R9 R6 serial reset drops done, leaves global untouched
    writeReg(2'd1, 8'h01, 1);
    readReg(2'd3, rd); check("R9 done low in serial reset", rd, 0);
    readReg(2'd0, rd); check("R6 global bit untouched", rd, 0);
    check("R6 global not asserted by serial", globalRstN, 1);
    readReg(2'd1, rd); check("R6 serial bit held", rd, 1);

    // R5 R3 pin low clears serial bit asynchronously
    @(negedge clk);
    #2; extRstN = 1'b0;
    #1; check("R3 async assertion", globalRstN, 0);
    check("R4 async bus off", busOe, 0);
    readReg(2'd1, rd); check("R5 pin clears serial bit", rd, 0);
    @(negedge clk); extRstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 pin low clears global bit
    writeReg(2'd0, 8'h01, 1);
    @(negedge clk); extRstN = 1'b0;
    @(negedge clk); extRstN = 1'b1;
    repeat (2) @(negedge clk);
    readReg(2'd0, rd); check("R2 pin clears global bit", rd, 0);
    check("R1 global released", globalRstN, 1);

    // R11 long hold
    writeReg(2'd0, 8'h01, 0);
    repeat (200) @(negedge clk);
    check("R11 global held", globalRstN, 0);
    check("R11 serial held", serRstN, 0);
    readReg(2'd0, rd); check("R11 bit still set", rd, 1);
    writeReg(2'd0, 8'h00, 1);
    check("R11 released by zero write", globalRstN, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule